// File: doc/BRIEF.md
# Fractional Stage-Count Dither Controller

This block steers a digitally controlled ring oscillator toward a fractional chain length. Each clock stands for one oscillator cycle. The block turns an 8-bit stage control word into a stage-count request and a divide-by-two enable for every cycle. The upper three bits choose a coarse nominal chain length. The lower five bits say how many cycles in each 32-cycle frame run at a longer alternate operating point. Averaged over a frame, the ring therefore behaves as if it had a non-integer number of stage delays. One step of the least significant fine bit is the smallest period correction the ring can make, roughly 0.2 to 0.37 percent.

A 5-bit phase accumulator adds the fine value once per cycle, and a carry out selects the alternate point. This spreads the longer cycles as evenly as possible across the frame. A new control word is captured only at a frame boundary, so every frame holds exactly the programmed number of alternate cycles. A single-cycle frame-start output marks the first cycle of each frame.

For coarse codes 0 to 6 the alternate point is the nominal chain plus two stages. For the top coarse code the alternate point is a chain of 17 stages with the divide-by-two enabled, which gives an effective 34 stage delays. The nominal point for that code is 31 stages.

Top module: `stage_dither_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `stage_count` = 17, `div2_en` = 0, `alt_point` = 0 and `frame_start` = 0. The captured control word becomes 8'h00, so the first frame after reset has no alternate cycles and requests 17 stages in every cycle.
- R2: `frame_start` is high in exactly one cycle of every 32. It marks cycle 0 of each output frame.
- R3: In every frame, the number of cycles with `alt_point` high equals the fine value `ctrl_word[4:0]` in use for that frame, for any value from 0 to 31.
- R4: Number the cycles of a frame j = 0..31 and let F be the fine value. Cycle j uses the alternate point exactly when floor((j+1)·F/32) > floor(j·F/32).
- R5: For coarse code c = `ctrl_word[7:5]` in 0..6, `stage_count` is 17+2c in nominal cycles and 19+2c in alternate cycles, and `div2_en` stays 0.
- R6: For coarse code 7, `stage_count` is 31 with `div2_en` = 0 in nominal cycles, and 17 with `div2_en` = 1 in alternate cycles.
- R7: `ctrl_word` is captured at the clock edge that ends output cycle 30 of a frame. The captured value governs the whole next frame. Changes at any other time, including changes made earlier in the same frame, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 8 | Stage control word: [7:5] coarse code, [4:0] fine count |
| stage_count | output | 6 | Requested ring stage count for this cycle |
| div2_en | output | 1 | Divide-by-two enable for this cycle |
| alt_point | output | 1 | High when this cycle uses the alternate operating point |
| frame_start | output | 1 | High in the first cycle of each 32-cycle frame |

## Verification
The hardest behaviour to reach from the ports is the capture window. A word that changes in the middle of a frame must not disturb the current frame, and only the value present at the last capture edge may reach the next one. The stimulus therefore writes a decoy word early in each frame and overwrites it with the real word at a random later cycle before the capture edge. The bench then checks every cycle of the following frame against the carry pattern worked out from the real word. Directed frames cover fine values 0, 1 and 31 for both the plain coarse codes and the divide-by-two code, and random words fill in the rest.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic {
    OP_NOMINAL   = 1'b0,
    OP_ALTERNATE = 1'b1
  } op_point_e;

  localparam int DEF_COARSE_W = 3;
  localparam int DEF_FINE_W   = 5;
  localparam int DEF_STAGE_W  = 6;
  localparam int DEF_BASE     = 17;
  localparam int DEF_STEP     = 2;

endpackage

// File: rtl/sdc_frame_timer.sv
module sdc_frame_timer #(
  parameter int FINE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  output logic [FINE_W-1:0] pos,
  output logic              first,
  output logic              last
);

  localparam logic [FINE_W-1:0] POS_LAST = {FINE_W{1'b1}};

  logic [FINE_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else     pos_q <= pos_q + 1'b1;
  end

  assign pos   = pos_q;
  assign first = (pos_q == '0);
  assign last  = (pos_q == POS_LAST);

endmodule

// File: rtl/sdc_phase_accum.sv
module sdc_phase_accum #(
  parameter int FINE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_last,
  input  logic [FINE_W-1:0] fine,
  output logic              carry
);

  logic [FINE_W-1:0] acc_q;
  logic [FINE_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, fine};
  assign carry = sum[FINE_W];

  // The accumulator returns to zero after a full frame of adds. Clearing it
  // at the frame edge keeps every frame's pattern anchored at phase zero.
  always_ff @(posedge clk) begin
    if (rst || frame_last) acc_q <= '0;
    else                   acc_q <= sum[FINE_W-1:0];
  end

endmodule

// File: rtl/sdc_stage_map.sv
module sdc_stage_map
  import sdc_pkg::*;
#(
  parameter int COARSE_W  = 3,
  parameter int STAGE_W   = 6,
  parameter int BASE      = 17,
  parameter int STEP      = 2,
  parameter bit TOP_HALVE = 1'b1
) (
  input  logic [COARSE_W-1:0] coarse,
  input  op_point_e           point,
  output logic [STAGE_W-1:0]  stages,
  output logic                div2
);

  localparam logic [COARSE_W-1:0] TOP_CODE = {COARSE_W{1'b1}};

  logic [STAGE_W-1:0] nominal;
  logic [STAGE_W-1:0] longer;

  always_comb begin
    nominal = STAGE_W'(BASE + STEP * int'(coarse));
    longer  = STAGE_W'(BASE + STEP * int'(coarse) + STEP);
  end

  generate
    if (TOP_HALVE) begin : g_halve
      always_comb begin
        if (point == OP_NOMINAL) begin
          stages = nominal;
          div2   = 1'b0;
        end else if (coarse == TOP_CODE) begin
          stages = STAGE_W'(BASE);
          div2   = 1'b1;
        end else begin
          stages = longer;
          div2   = 1'b0;
        end
      end
    end else begin : g_plain
      always_comb begin
        stages = (point == OP_NOMINAL) ? nominal : longer;
        div2   = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/stage_dither_ctrl.sv
module stage_dither_ctrl
  import sdc_pkg::*;
#(
  parameter int COARSE_W = DEF_COARSE_W,
  parameter int FINE_W   = DEF_FINE_W,
  parameter int STAGE_W  = DEF_STAGE_W,
  parameter int BASE     = DEF_BASE,
  parameter int STEP     = DEF_STEP
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [COARSE_W+FINE_W-1:0] ctrl_word,
  output logic [STAGE_W-1:0]         stage_count,
  output logic                       div2_en,
  output logic                       alt_point,
  output logic                       frame_start
);

  localparam int CTRL_W = COARSE_W + FINE_W;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [FINE_W-1:0]   frame_pos;
  logic                frame_first;
  logic                frame_last;
  logic                carry;
  op_point_e           point;
  logic [STAGE_W-1:0]  stages_d;
  logic                div2_d;

  always_ff @(posedge clk) begin
    if (rst)             ctrl_q <= '0;
    else if (frame_last) ctrl_q <= ctrl_word;
  end

  sdc_frame_timer #(.FINE_W(FINE_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .pos   (frame_pos),
    .first (frame_first),
    .last  (frame_last)
  );

  sdc_phase_accum #(.FINE_W(FINE_W)) u_accum (
    .clk        (clk),
    .rst        (rst),
    .frame_last (frame_last),
    .fine       (ctrl_q[FINE_W-1:0]),
    .carry      (carry)
  );

  assign point = carry ? OP_ALTERNATE : OP_NOMINAL;

  sdc_stage_map #(
    .COARSE_W  (COARSE_W),
    .STAGE_W   (STAGE_W),
    .BASE      (BASE),
    .STEP      (STEP),
    .TOP_HALVE (1'b1)
  ) u_map (
    .coarse (ctrl_q[CTRL_W-1:FINE_W]),
    .point  (point),
    .stages (stages_d),
    .div2   (div2_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_count <= STAGE_W'(BASE);
      div2_en     <= 1'b0;
      alt_point   <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      stage_count <= stages_d;
      div2_en     <= div2_d;
      alt_point   <= carry;
      frame_start <= frame_first;
    end
  end

endmodule

// File: rtl/stage_dither_chk.sv
module stage_dither_chk #(
  parameter int FINE_W  = 5,
  parameter int CTRL_W  = 8,
  parameter int STAGE_W = 6,
  parameter int BASE    = 17
) (
  input logic               clk,
  input logic               rst,
  input logic [CTRL_W-1:0]  ctrl_q,
  input logic [FINE_W-1:0]  frame_pos,
  input logic [STAGE_W-1:0] stage_count,
  input logic               div2_en,
  input logic               alt_point,
  input logic               frame_start
);

  localparam int FRAME = 1 << FINE_W;
  localparam logic [FINE_W-1:0] POS_LAST = {FINE_W{1'b1}};

  logic              seen;
  logic [FINE_W+1:0] gap;
  logic [FINE_W:0]   alt_cnt;
  logic [FINE_W-1:0] exp_fine;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= 1'b0;
      gap      <= '0;
      alt_cnt  <= '0;
      exp_fine <= '0;
    end else if (frame_start) begin
      seen     <= 1'b1;
      gap      <= 1;
      alt_cnt  <= {{FINE_W{1'b0}}, alt_point};
      exp_fine <= ctrl_q[FINE_W-1:0];
    end else begin
      if (gap != '1) gap <= gap + 1'b1;
      alt_cnt <= alt_cnt + {{FINE_W{1'b0}}, alt_point};
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (stage_count == STAGE_W'(BASE) && !div2_en && !alt_point && !frame_start));

  // R2
  frame_period_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && frame_start) |-> (gap == (FINE_W+2)'(FRAME)));

  // R2
  frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && !frame_start) |-> (gap < (FINE_W+2)'(FRAME)));

  // R3
  alt_count_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && frame_start) |-> (alt_cnt == {1'b0, exp_fine}));

  // R6
  halved_point_chk: assert property (@(posedge clk) disable iff (rst)
    div2_en |-> (alt_point && stage_count == STAGE_W'(BASE)));

  // R7
  capture_window_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_pos != POS_LAST) |=> $stable(ctrl_q));

endmodule

bind stage_dither_ctrl stage_dither_chk #(
  .FINE_W  (FINE_W),
  .CTRL_W  (COARSE_W + FINE_W),
  .STAGE_W (STAGE_W),
  .BASE    (BASE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctrl_q      (ctrl_q),
  .frame_pos   (frame_pos),
  .stage_count (stage_count),
  .div2_en     (div2_en),
  .alt_point   (alt_point),
  .frame_start (frame_start)
);

// File: tb/stage_dither_ctrl_bench.sv
`timescale 1ns/1ps
module stage_dither_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ctrl_word = 8'hA5;
  logic [5:0] stage_count;
  logic       div2_en;
  logic       alt_point;
  logic       frame_start;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  stage_dither_ctrl u_stage_dither_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ctrl_word   (ctrl_word),
    .stage_count (stage_count),
    .div2_en     (div2_en),
    .alt_point   (alt_point),
    .frame_start (frame_start)
  );

  function automatic bit exp_alt(input int j, input int f);
    return (((j + 1) * f) / 32) != ((j * f) / 32);
  endfunction

  function automatic int exp_stage(input int c, input bit alt);
    if (c == 7) return alt ? 17 : 31;
    return alt ? 19 + 2 * c : 17 + 2 * c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Runs one output frame starting at a negedge where frame_start is high.
  task automatic run_frame(input logic [7:0] cur, input logic [7:0] nxt,
                           input logic [7:0] decoy, input int set_at);
    int c;
    int f;
    int cnt;
    bit a;
    c   = int'(cur[7:5]);
    f   = int'(cur[4:0]);
    cnt = 0;
    for (int j = 0; j < 32; j++) begin
      a = exp_alt(j, f);
      check(frame_start == (j == 0), "R2 frame_start", int'(frame_start), int'(j == 0));
      check(alt_point == a, "R4 alt placement", int'(alt_point), int'(a));
      if (c == 7) begin
        check(int'(stage_count) == exp_stage(c, a), "R6 stage_count", int'(stage_count), exp_stage(c, a));
        check(div2_en == a, "R6 div2_en", int'(div2_en), int'(a));
      end else begin
        check(int'(stage_count) == exp_stage(c, a), "R5 stage_count", int'(stage_count), exp_stage(c, a));
        check(div2_en == 1'b0, "R5 div2_en", int'(div2_en), 0);
      end
      if (alt_point) cnt++;
      if (j == 2) ctrl_word = decoy;
      if (j == set_at) ctrl_word = nxt;
      @(negedge clk);
    end
    check(cnt == f, "R3 alt count per frame", cnt, f);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog timeout");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] cur;
    logic [7:0] nxt;
    logic [7:0] directed [10];
    int waits;
    void'($urandom(32'h5EED_1234));
    directed[0] = 8'h60; directed[1] = 8'h61; directed[2] = 8'h7F;
    directed[3] = 8'hE0; directed[4] = 8'hE1; directed[5] = 8'hFF;
    directed[6] = 8'h10; directed[7] = 8'hD5; directed[8] = 8'h1F;
    directed[9] = 8'h00;

    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(stage_count == 6'd17, "R1 reset stage_count", int'(stage_count), 17);
      check(div2_en == 1'b0, "R1 reset div2_en", int'(div2_en), 0);
      check(alt_point == 1'b0, "R1 reset alt_point", int'(alt_point), 0);
      check(frame_start == 1'b0, "R1 reset frame_start", int'(frame_start), 0);
    end
    rst = 1'b0;
    waits = 0;
    @(negedge clk);
    while (!frame_start && waits < 5) begin
      waits++;
      @(negedge clk);
    end
    check(frame_start == 1'b1, "R2 first frame_start", int'(frame_start), 1);

    // R1: first frame uses the reset word 8'h00, despite ctrl_word = 8'hA5.
    cur = 8'h00;
    for (int i = 0; i < 40; i++) begin
      if (i < 10) nxt = directed[i];
      else        nxt = 8'($urandom());
      // R7: a decoy word written early must be overwritten without effect.
      run_frame(cur, nxt, ~nxt, 3 + int'($urandom_range(25)));
      cur = nxt;
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule